// File: doc/BRIEF.md
# Way-Partitioned Set-Associative Data Cache

This block is a write-back, write-allocate set-associative data cache in which every way acts as an independent partition. Each load or store carries a way-select vector and a restrict flag. Software uses these to decide which ways the access may probe and which ways it may evict. When the flag is set, only the selected ways have their tags compared and their data read, so an access stream pinned to one way costs one tag check. When the flag is clear, every way is probed. On a miss, the new line always lands in one of the selected ways, whatever the flag says.

Requests use a valid/ready handshake. A hit returns its response one cycle after acceptance. A miss holds ready low while the cache talks to a word-serial backing memory: first it writes back any dirty line that must leave, then it reads the new line word by word. Each response reports how many ways the lookup activated.

The controller has four states. IDLE accepts requests and serves hits. FLUSH writes one dirty line back, one word per beat. REFILL reads the missing line, one word per beat. FINISH installs the tag, merges any store data, updates recency and responds. The transitions are as follows:
- IDLE goes to FLUSH on a miss that needs a write-back.
- IDLE goes to REFILL on a miss with nothing to write back.
- FLUSH repeats itself for a second dirty line when one is pending, and otherwise goes to REFILL after the last beat.
- REFILL goes to FINISH after the last beat.
- FINISH always returns to IDLE.

Top module: `pcache_top`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, mem_req is 0, and every line is invalid, so the first access to any address misses.
- R2: A request accepted while its line is resident in a probed way produces resp_valid with resp_hit=1 in the next cycle. Reads return the stored word. Writes return the written word.
- R3: probe_count equals the number of 1 bits in req_ways when req_restrict=1, and equals NUM_WAYS when req_restrict=0. It is reported with every response, hit or miss.
- R4: With req_restrict=1, a line resident only in a way outside req_ways is treated as a miss. That copy is invalidated and the line is refilled into a selected way.
- R5: With req_restrict=0, a line resident in any way hits, even if that way is outside req_ways.
- R6: On a miss, the refilled way is always a way selected in req_ways. The lowest-numbered invalid selected way is preferred. Otherwise the least recently used selected way is chosen.
- R7: An all-zero req_ways is treated as all ways selected, for both lookup and replacement.
- R8: A store miss allocates the line and marks it dirty. Evicting a dirty line writes its LINE_WORDS words to the backing port, at word addresses {tag, set, word} in ascending word order, before any refill read starts.
- R9: During a miss, req_ready stays 0 and mem_req is 1 until the refill completes. The miss response has resp_hit=0 and carries the correct word. mem_req is 0 whenever req_ready is 1.
- R10: When a restricted miss finds a dirty copy of the line outside req_ways, that copy is written back before the refill, so the refill returns the latest data.
- R11: Recency is updated on every hit and every fill, so a line touched after another line becomes the more recently used of the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| req_wdata | input | DATA_W | Store data |
| req_ways | input | NUM_WAYS | Way-select vector, bit w selects way w |
| req_restrict | input | 1 | 1 = probe only selected ways |
| resp_valid | output | 1 | Response present for one cycle |
| resp_hit | output | 1 | Response came from a hit |
| resp_rdata | output | DATA_W | Read data, or the stored word for writes |
| probe_count | output | CNT_W | Ways activated by the lookup |
| mem_req | output | 1 | Backing memory beat requested |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W-2 | Backing word address |
| mem_wdata | output | DATA_W | Write-back word |
| mem_ack | input | 1 | Beat completes this cycle |
| mem_rdata | input | DATA_W | Refill word, valid with mem_ack |

## Verification
The properties assume the backing port raises mem_ack only while mem_req is high, with mem_rdata valid in that same cycle. They also assume a requester holds its request fields steady until the request is accepted. The bench acknowledges every beat in the cycle it is requested, from an array that it updates on write beats. It raises req_valid only at a falling edge and drops it right after the accepting edge, so no request changes while it waits. Under these conditions every accepted request either hits in the next cycle or drops req_ready, and the rules on write-backs and refills hold.

// File: rtl/pcache_pkg.sv
package pcache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FLUSH  = 2'd1,
        ST_REFILL = 2'd2,
        ST_FINISH = 2'd3
    } pc_state_e;
endpackage

// File: rtl/pcache_lookup.sv
module pcache_lookup #(
    parameter int NUM_WAYS = 4,
    parameter int TAG_W    = 9,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int CNT_W   = $clog2(NUM_WAYS + 1)
) (
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] tags,
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [TAG_W-1:0]               probe_tag,
    input  logic [NUM_WAYS-1:0]            ways,
    input  logic                           restrict_en,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way,
    output logic                           shadow,
    output logic [WAY_W-1:0]               shadow_way,
    output logic [CNT_W-1:0]               probe_cnt
);
    logic [NUM_WAYS-1:0] match;
    logic [NUM_WAYS-1:0] enabled;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == probe_tag);
    end

    assign enabled = restrict_en ? ways : {NUM_WAYS{1'b1}};

    always_comb begin
        hit        = 1'b0;
        hit_way    = '0;
        shadow     = 1'b0;
        shadow_way = '0;
        probe_cnt  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (enabled[w]) probe_cnt = probe_cnt + CNT_W'(1);
            if (match[w] && enabled[w]) begin
                hit     = 1'b1;
                hit_way = WAY_W'(w);
            end
            if (match[w] && !enabled[w]) begin
                shadow     = 1'b1;
                shadow_way = WAY_W'(w);
            end
        end
    end
endmodule

// File: rtl/pcache_victim.sv
module pcache_victim #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0]            valid,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] age,
    input  logic [NUM_WAYS-1:0]            ways,
    output logic [WAY_W-1:0]               victim
);
    logic             found_free;
    logic             have_old;
    logic [WAY_W-1:0] oldest;

    always_comb begin
        found_free = 1'b0;
        have_old   = 1'b0;
        oldest     = '0;
        victim     = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (ways[w] && !valid[w] && !found_free) begin
                found_free = 1'b1;
                victim     = WAY_W'(w);
            end
        end
        if (!found_free) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (ways[w] && (!have_old || age[w] > oldest)) begin
                    have_old = 1'b1;
                    oldest   = age[w];
                    victim   = WAY_W'(w);
                end
            end
        end
    end
endmodule

// File: rtl/pcache_age.sv
module pcache_age #(
    parameter int NUM_WAYS = 4,
    localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0][WAY_W-1:0] age_in,
    input  logic [WAY_W-1:0]               touch,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] age_out
);
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_age
        always_comb begin
            if (WAY_W'(w) == touch)
                age_out[w] = '0;
            else if (age_in[w] < age_in[touch])
                age_out[w] = age_in[w] + WAY_W'(1);
            else
                age_out[w] = age_in[w];
        end
    end
endmodule

// File: rtl/pcache_top.sv
module pcache_top
    import pcache_pkg::*;
#(
    parameter int NUM_WAYS   = 4,
    parameter int NUM_SETS   = 4,
    parameter int LINE_WORDS = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 32,
    localparam int CNT_W     = $clog2(NUM_WAYS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [NUM_WAYS-1:0] req_ways,
    input  logic                req_restrict,
    output logic                resp_valid,
    output logic                resp_hit,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic [CNT_W-1:0]    probe_count,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-3:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic                mem_ack,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int WOFF_W = $clog2(LINE_WORDS);
    localparam int BOFF_W = WOFF_W + 2;
    localparam int TAG_W  = ADDR_W - SET_W - BOFF_W;

    pc_state_e state_q, state_d;

    logic [NUM_WAYS-1:0][TAG_W-1:0] tag_q   [NUM_SETS];
    logic [NUM_WAYS-1:0]            valid_q [NUM_SETS];
    logic [NUM_WAYS-1:0]            dirty_q [NUM_SETS];
    logic [NUM_WAYS-1:0][WAY_W-1:0] age_q   [NUM_SETS];
    logic [DATA_W-1:0]              data_q  [NUM_SETS][NUM_WAYS][LINE_WORDS];

    logic [ADDR_W-1:0]   addr_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [NUM_WAYS-1:0] mask_q;
    logic [WAY_W-1:0]    victim_q, wb_way_q;
    logic                wb_shadow_q, vic_dirty_q;
    logic [WOFF_W-1:0]   word_q;
    logic [CNT_W-1:0]    probe_q;

    logic [NUM_WAYS-1:0] eff_ways;
    logic [ADDR_W-1:0]   cur_addr;
    logic [TAG_W-1:0]    c_tag;
    logic [SET_W-1:0]    c_set;
    logic [WOFF_W-1:0]   c_woff;
    logic                hit, shadow;
    logic [WAY_W-1:0]    hit_way, shadow_way, vic_now, touch_way;
    logic [CNT_W-1:0]    probe_now;
    logic [NUM_WAYS-1:0][WAY_W-1:0] age_next;
    logic                accept, acc_hit, acc_miss, beat, last_word;
    logic                vic_dirty_now, shadow_dirty;

    assign eff_ways  = (req_ways == '0) ? {NUM_WAYS{1'b1}} : req_ways;
    assign cur_addr  = (state_q == ST_IDLE) ? req_addr : addr_q;
    assign c_tag     = cur_addr[ADDR_W-1 -: TAG_W];
    assign c_set     = cur_addr[BOFF_W +: SET_W];
    assign c_woff    = cur_addr[2 +: WOFF_W];
    assign touch_way = (state_q == ST_IDLE) ? hit_way : victim_q;

    pcache_lookup #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) u_lookup (
        .tags(tag_q[c_set]), .valid(valid_q[c_set]), .probe_tag(c_tag),
        .ways(eff_ways), .restrict_en(req_restrict), .hit(hit), .hit_way(hit_way),
        .shadow(shadow), .shadow_way(shadow_way), .probe_cnt(probe_now)
    );

    pcache_victim #(.NUM_WAYS(NUM_WAYS)) u_victim (
        .valid(valid_q[c_set]), .age(age_q[c_set]), .ways(eff_ways), .victim(vic_now)
    );

    pcache_age #(.NUM_WAYS(NUM_WAYS)) u_age (
        .age_in(age_q[c_set]), .touch(touch_way), .age_out(age_next)
    );

    assign accept        = req_valid && (state_q == ST_IDLE);
    assign acc_hit       = accept && hit;
    assign acc_miss      = accept && !hit;
    assign beat          = mem_req && mem_ack;
    assign last_word     = (word_q == WOFF_W'(LINE_WORDS - 1));
    assign vic_dirty_now = valid_q[c_set][vic_now] && dirty_q[c_set][vic_now];
    assign shadow_dirty  = shadow && dirty_q[c_set][shadow_way];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_miss) state_d = (shadow_dirty || vic_dirty_now) ? ST_FLUSH : ST_REFILL;
            ST_FLUSH:  if (beat && last_word) state_d = (wb_shadow_q && vic_dirty_q) ? ST_FLUSH : ST_REFILL;
            ST_REFILL: if (beat && last_word) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Miss bookkeeping: request capture and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0; we_q <= 1'b0; wdata_q <= '0; mask_q <= '0;
            victim_q <= '0; wb_way_q <= '0; wb_shadow_q <= 1'b0;
            vic_dirty_q <= 1'b0; word_q <= '0; probe_q <= '0;
        end else begin
            if (acc_miss) begin
                addr_q      <= req_addr;
                we_q        <= req_write;
                wdata_q     <= req_wdata;
                mask_q      <= eff_ways;
                victim_q    <= vic_now;
                probe_q     <= probe_now;
                word_q      <= '0;
                wb_shadow_q <= shadow_dirty;
                wb_way_q    <= shadow_dirty ? shadow_way : vic_now;
                vic_dirty_q <= vic_dirty_now;
            end
            if (beat) word_q <= word_q + WOFF_W'(1);
            if (state_q == ST_FLUSH && beat && last_word && wb_shadow_q) begin
                wb_shadow_q <= 1'b0;
                wb_way_q    <= victim_q;
            end
        end
    end

    // Line state: valid, dirty, recency
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
                for (int w = 0; w < NUM_WAYS; w++) age_q[s][w] <= WAY_W'(w);
            end
        end else begin
            if (acc_hit) begin
                age_q[c_set] <= age_next;
                if (req_write) dirty_q[c_set][hit_way] <= 1'b1;
            end
            if (acc_miss && shadow) begin
                valid_q[c_set][shadow_way] <= 1'b0;
                dirty_q[c_set][shadow_way] <= 1'b0;
            end
            if (state_q == ST_FINISH) begin
                valid_q[c_set][victim_q] <= 1'b1;
                dirty_q[c_set][victim_q] <= we_q;
                age_q[c_set]             <= age_next;
            end
        end
    end

    // Tag and data arrays
    always_ff @(posedge clk) begin
        if (acc_hit && req_write) data_q[c_set][hit_way][c_woff] <= req_wdata;
        if (state_q == ST_REFILL && beat) data_q[c_set][victim_q][word_q] <= mem_rdata;
        if (state_q == ST_FINISH) begin
            tag_q[c_set][victim_q] <= c_tag;
            if (we_q) data_q[c_set][victim_q][c_woff] <= wdata_q;
        end
    end

    // Response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_valid <= 1'b0; resp_hit <= 1'b0; resp_rdata <= '0; probe_count <= '0;
        end else begin
            resp_valid <= acc_hit || (state_q == ST_FINISH);
            if (acc_hit) begin
                resp_hit    <= 1'b1;
                resp_rdata  <= req_write ? req_wdata : data_q[c_set][hit_way][c_woff];
                probe_count <= probe_now;
            end else if (state_q == ST_FINISH) begin
                resp_hit    <= 1'b0;
                resp_rdata  <= we_q ? wdata_q : data_q[c_set][victim_q][c_woff];
                probe_count <= probe_q;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign mem_req   = (state_q == ST_FLUSH) || (state_q == ST_REFILL);
    assign mem_we    = (state_q == ST_FLUSH);
    assign mem_addr  = (state_q == ST_FLUSH) ? {tag_q[c_set][wb_way_q], c_set, word_q}
                                             : {c_tag, c_set, word_q};
    assign mem_wdata = data_q[c_set][wb_way_q][word_q];
endmodule

// File: rtl/pcache_chk.sv
module pcache_chk #(
    parameter int NUM_WAYS = 4,
    parameter int CNT_W    = 3,
    parameter int WAY_W    = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                resp_valid,
    input logic                resp_hit,
    input logic [CNT_W-1:0]    probe_count,
    input logic                mem_req,
    input logic                mem_we,
    input logic                mem_ack,
    input logic [WAY_W-1:0]    fill_way,
    input logic [NUM_WAYS-1:0] fill_mask,
    input logic                in_refill
);
    p_hit_next_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ((resp_valid && resp_hit) || !req_ready));

    p_probe_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (probe_count >= CNT_W'(1) && probe_count <= CNT_W'(NUM_WAYS)));

    p_fill_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_refill |-> fill_mask[fill_way]);

    p_no_wb_after_refill_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> !(mem_req && mem_we));

    p_idle_mem_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req);

    p_miss_resp_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_hit) |-> $past(!req_ready));
endmodule

bind pcache_top pcache_chk #(.NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W), .WAY_W(WAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .probe_count(probe_count),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
    .fill_way(victim_q), .fill_mask(mask_q), .in_refill(state_q == pcache_pkg::ST_REFILL)
);

// File: tb/tb_pcache_top.sv
`timescale 1ns/1ps
module tb_pcache_top;
    localparam int NW = 4;
    localparam int AW = 16;
    localparam int MW = 1 << (AW - 2);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0, req_restrict = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [NW-1:0] req_ways = '0;
    logic          req_ready, resp_valid, resp_hit;
    logic [31:0]   resp_rdata;
    logic [2:0]    probe_count;
    logic          mem_req, mem_we, mem_ack;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;

    logic [31:0] mem  [MW];
    logic [31:0] refm [MW];

    int n_tests = 0, n_fail = 0;
    int rd_beats = 0, wr_beats = 0, order_bad = 0;
    int first_wr = -1;
    logic        got_hit;
    logic [31:0] got_data;
    int          got_probe, got_wait;

    always #4 clk = ~clk;

    pcache_top dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ways(req_ways), .req_restrict(req_restrict), .resp_valid(resp_valid),
        .resp_hit(resp_hit), .resp_rdata(resp_rdata), .probe_count(probe_count),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    assign mem_ack   = mem_req;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (first_wr < 0) first_wr = int'(mem_addr);
                if (rd_beats > 0) order_bad = 1;
                wr_beats = wr_beats + 1;
            end else begin
                rd_beats = rd_beats + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_probe(input logic [NW-1:0] m, input logic r);
        if (r && m != '0) return $countones(m);
        return NW;
    endfunction

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [NW-1:0] m, input logic r);
        @(negedge clk);
        rd_beats = 0; wr_beats = 0; order_bad = 0; first_wr = -1;
        req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
        req_ways = m; req_restrict = r;
        if (we) refm[a >> 2] = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        got_wait = 0;
        while (!resp_valid) begin
            @(negedge clk);
            got_wait++;
        end
        got_hit = resp_hit; got_data = resp_rdata; got_probe = int'(probe_count);
        check(got_data == refm[a >> 2], "R2", "data", got_data, refm[a >> 2]);
        check(got_probe == exp_probe(m, r), "R3", "probe count", got_probe, exp_probe(m, r));
        if (got_hit) check(got_wait == 0, "R2", "hit latency", got_wait, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < MW; i++) begin
            mem[i]  = (i * 32'h01000193) ^ 32'h5a5a0000;
            refm[i] = (i * 32'h01000193) ^ 32'h5a5a0000;
        end
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
        rst_n = 1'b1;

        // set 0: restricted and unrestricted lookups
        access(0, 16'h0000, 0, 4'b0001, 1);
        check(!got_hit, "R1", "cold miss", got_hit, 0);
        check(rd_beats == 8, "R9", "refill beats", rd_beats, 8);
        access(0, 16'h0004, 0, 4'b0001, 1);
        check(got_hit, "R2", "resident hit", got_hit, 1);
        access(0, 16'h0000, 0, 4'b0010, 1);
        check(!got_hit, "R4", "copy outside mask misses", got_hit, 0);
        access(0, 16'h0000, 0, 4'b0001, 1);
        check(!got_hit, "R4", "old way invalidated", got_hit, 0);
        access(0, 16'h0000, 0, 4'b0100, 0);
        check(got_hit, "R5", "unrestricted hit outside mask", got_hit, 1);
        access(0, 16'h0000, 0, 4'b0000, 1);
        check(got_hit && got_probe == 4, "R7", "zero mask probes all", got_probe, 4);

        // set 1: dirty eviction order and address
        access(1, 16'h00A8, 32'hCAFE0001, 4'b0100, 1);
        check(!got_hit && wr_beats == 0, "R8", "store miss allocates", wr_beats, 0);
        access(0, 16'h0120, 0, 4'b0100, 1);
        check(wr_beats == 8, "R8", "write-back beats", wr_beats, 8);
        check(order_bad == 0, "R8", "write-back before refill", order_bad, 0);
        check(first_wr == 16'h00A0 >> 2, "R8", "write-back base address", first_wr, 16'h00A0 >> 2);
        check(mem[16'h00A8 >> 2] == 32'hCAFE0001, "R8", "memory holds store", mem[16'h00A8 >> 2], 32'hCAFE0001);
        access(0, 16'h00A8, 0, 4'b0100, 1);
        check(!got_hit, "R9", "evicted line misses", got_hit, 0);

        // set 2: dirty copy outside mask
        access(1, 16'h00C0, 32'hBEEF0002, 4'b0001, 1);
        access(0, 16'h00C0, 0, 4'b0010, 1);
        check(wr_beats == 8, "R10", "dirty shadow flushed", wr_beats, 8);
        check(got_data == 32'hBEEF0002, "R10", "latest data", got_data, 32'hBEEF0002);
        access(0, 16'h00C0, 0, 4'b0001, 1);
        check(!got_hit && wr_beats == 0, "R10", "shadow not kept", wr_beats, 0);

        // set 3: replacement confined and recency
        access(0, 16'h00E0, 0, 4'b0011, 1);
        access(0, 16'h0160, 0, 4'b0011, 1);
        access(0, 16'h00E0, 0, 4'b0011, 1);
        check(got_hit, "R11", "first line resident", got_hit, 1);
        access(0, 16'h01E0, 0, 4'b0011, 1);
        access(0, 16'h00E0, 0, 4'b0011, 1);
        check(got_hit, "R11", "recent line kept", got_hit, 1);
        access(0, 16'h0160, 0, 4'b0011, 1);
        check(!got_hit, "R6", "LRU line evicted", got_hit, 0);
        access(0, 16'h0260, 0, 4'b1100, 1);
        access(0, 16'h00E0, 0, 4'b0011, 1);
        check(got_hit, "R6", "fill stayed in its ways", got_hit, 1);
        access(0, 16'h0160, 0, 4'b0011, 1);
        check(got_hit, "R6", "other line untouched", got_hit, 1);

        // sweep every mask and flag with mixed traffic
        begin
            logic [31:0] seed = 32'h1234_5678;
            for (int r = 0; r < 2; r++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int k = 0; k < 8; k++) begin
                        seed = seed * 32'd1103515245 + 32'd12345;
                        access(seed[4], AW'((seed >> 8) & 32'h03FC), seed ^ 32'h0F0F0F0F,
                               NW'(m), r[0]);
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule